// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block supplies the word address for a synchronous burst memory. Each rising clock edge it either captures a fresh external address, steps the two lowest address bits to the next beat of a four-beat burst, or keeps the address it already has. Two strobe inputs can start a burst. One is processor-side and counts only while the chip enable is high. The other is controller-side and always counts.

The beat order is picked at run time by a mode input, either linear (wrap-around increment) or interleaved (XOR with the beat index). The bits above the lowest two stay fixed for the whole burst. A registered flag marks the fourth address of a burst. Bursting is optional: a fresh address can be loaded on every cycle, and each one appears at the output on the next cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-high reset is applied, `addr_o` equals parameter `RESET_ADDR` and `last_o` is 0.
- R2: When `load_ctl` is 1 at a rising edge, `addr_o` equals the sampled `addr_i` after that edge, whatever `chip_en` is, and `last_o` is 0.
- R3: `load_cpu` loads `addr_i` only when `chip_en` is 1 at the same edge. With `chip_en` at 0, `load_cpu` alone has no effect: the block holds or advances as if no strobe were present.
- R4: With `lin_mode` at 1 (linear), after k advances since a load whose low bits were s, the low two bits of `addr_o` equal (s + k) mod 4.
- R5: With `lin_mode` at 0 (interleaved), after k advances since a load whose low bits were s, the low two bits of `addr_o` equal s XOR (k mod 4).
- R6: Bits `AW-1` down to 2 of `addr_o` change only on a load.
- R7: With no effective strobe and `step_i` at 0, `addr_o` and `last_o` keep their values.
- R8: A strobe and `step_i` asserted at the same edge perform a load, and no advance takes place.
- R9: `last_o` is 1 exactly when three advances have occurred since the last load, counted modulo 4. A fourth advance returns the low bits to the start value and clears `last_o`.
- R10: A new address loaded on every consecutive cycle appears on `addr_o` one cycle after each load, with no cycle lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Qualifies the processor-side strobe |
| load_cpu | input | 1 | Processor-side address strobe |
| load_ctl | input | 1 | Controller-side address strobe |
| step_i | input | 1 | Advance the burst by one beat |
| lin_mode | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_i | input | AW | External address |
| addr_o | output | AW | Current registered address |
| last_o | output | 1 | High on the fourth address of a burst |

## Verification
The stimulus runs full four-beat bursts in both orders, using start addresses whose low bits are not zero. A full burst is needed to tell the linear and interleaved sequences apart, and it also shows whether the wrap restores the start value and clears the last flag. Hold cycles and a burst with gaps between advances show that stepping happens only when requested. The processor strobe is sent with the chip enable both low and high, so the bench can tell the gated load from the ungated one. A strobe together with an advance, and a run of loads on consecutive cycles, show load priority and full-rate address loading.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef logic [1:0] beat_t;

  // low address bits for beat k of a burst that began at s
  function automatic beat_t beat_low(input beat_t s, input beat_t k, input logic lin);
    beat_t r;
    if (lin) r = s + k;
    else     r = s ^ k;
    return r;
  endfunction
endpackage

// File: rtl/bst_load_qual.sv
module bst_load_qual (
  input  logic chip_en,
  input  logic load_cpu,
  input  logic load_ctl,
  output logic load_o
);
  logic cpu_ok;
  assign cpu_ok = load_cpu & chip_en;
  assign load_o = cpu_ok | load_ctl;
endmodule

// File: rtl/bst_beat_ctr.sv
module bst_beat_ctr
  import bst_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  output beat_t beat_q,
  output beat_t beat_nxt,
  output logic  last_q
);
  localparam beat_t FINAL_BEAT = 2'd3;

  always_comb begin
    if (load)      beat_nxt = '0;
    else if (step) beat_nxt = beat_q + 2'd1;
    else           beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      last_q <= 1'b0;
    end else begin
      beat_q <= beat_nxt;
      last_q <= (beat_nxt == FINAL_BEAT);
    end
  end

  // R9: a load always clears the last-beat flag
  p_last_clear_on_load_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> !last_q);
  // R9: third advance raises the flag
  p_last_on_third_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && step && beat_q == 2'd2) |=> last_q);
endmodule

// File: rtl/bst_low_gen.sv
module bst_low_gen
  import bst_pkg::*;
(
  input  beat_t start_i,
  input  beat_t beat_i,
  input  logic  lin_i,
  output beat_t low_o
);
  assign low_o = beat_low(start_i, beat_i, lin_i);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bst_pkg::*;
#(
  parameter int          AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_en,
  input  logic          load_cpu,
  input  logic          load_ctl,
  input  logic          step_i,
  input  logic          lin_mode,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam int UW = AW - 2;

  logic          load;
  beat_t         beat_q, beat_nxt, start_q, low_nxt;
  logic [AW-1:0] addr_q, addr_nxt;

  bst_load_qual u_qual (
    .chip_en (chip_en),
    .load_cpu(load_cpu),
    .load_ctl(load_ctl),
    .load_o  (load)
  );

  bst_beat_ctr u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step_i),
    .beat_q  (beat_q),
    .beat_nxt(beat_nxt),
    .last_q  (last_o)
  );

  bst_low_gen u_low (
    .start_i(start_q),
    .beat_i (beat_nxt),
    .lin_i  (lin_mode),
    .low_o  (low_nxt)
  );

  always_comb begin
    if (load)        addr_nxt = addr_i;
    else if (step_i) addr_nxt = {addr_q[AW-1:2], low_nxt};
    else             addr_nxt = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= RESET_ADDR;
      start_q <= RESET_ADDR[1:0];
    end else begin
      addr_q <= addr_nxt;
      if (load) start_q <= addr_i[1:0];
    end
  end

  assign addr_o = addr_q;

  // R2 / R10: a load shows the sampled address on the next cycle
  p_load_visible_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> addr_o == $past(addr_i));
  // R6: upper bits move only on a load
  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> addr_o[AW-1:2] == $past(addr_o[AW-1:2]));
  // R7: idle cycles hold the address and flag
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_i) |=> ($stable(addr_o) && $stable(last_o)));
  // R3: an ungated processor strobe alone leaves the idle state alone
  p_cpu_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (!chip_en && load_cpu && !load_ctl && !step_i) |=> $stable(addr_o));
  // R8: a strobe with an advance restarts the beat count
  p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (load && step_i) |=> beat_q == 2'd0);
  // R1: reset value
  p_reset_val_r1: assert property (@(posedge clk)
    rst |=> (addr_o == RESET_ADDR && !last_o));
  initial assert (UW >= 1) else $error("AW must exceed 2");
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] RST_ADDR = 16'hA5A6;

  typedef struct {
    logic [AW-1:0] addr;
    logic          last;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic chip_en = 0, load_cpu = 0, load_ctl = 0, step_i = 0, lin_mode = 1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic last_o;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  // reference state
  logic [AW-1:0] m_addr = RST_ADDR;
  logic [1:0]    m_start = RST_ADDR[1:0];
  int            m_k = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.AW(AW), .RESET_ADDR(RST_ADDR)) u0 (
    .clk(clk), .rst(rst), .chip_en(chip_en), .load_cpu(load_cpu),
    .load_ctl(load_ctl), .step_i(step_i), .lin_mode(lin_mode),
    .addr_i(addr_i), .addr_o(addr_o), .last_o(last_o)
  );

  task automatic check(input logic [AW-1:0] ea, input logic el, input string tag);
    n_chk++;
    if (addr_o !== ea || last_o !== el) begin
      n_fail++;
      $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
               tag, addr_o, last_o, ea, el);
    end
  endtask

  // driver: applies one cycle of stimulus and predicts the result
  task automatic step(input logic ce, input logic sc, input logic sk,
                      input logic adv, input logic lin,
                      input logic [AW-1:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    chip_en = ce; load_cpu = sc; load_ctl = sk; step_i = adv;
    lin_mode = lin; addr_i = a;
    if ((sc && ce) || sk) begin
      m_addr = a; m_start = a[1:0]; m_k = 0;
    end else if (adv) begin
      m_k = (m_k + 1) % 4;
      if (lin) m_addr[1:0] = 2'((int'(m_start) + m_k) % 4);
      else     m_addr[1:0] = m_start ^ 2'(m_k);
    end
    e.addr = m_addr; e.last = (m_k == 3); e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares each result one step after its edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.addr, e.last, e.tag);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(RST_ADDR, 1'b0, "R1 reset value");
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, 0, 1, 16'h0000, "R1 idle after reset");

    // controller strobe with chip enable low, then linear burst
    step(0, 0, 1, 0, 1, 16'h1231, "R2 controller load");
    step(0, 0, 0, 1, 1, 16'hFFFF, "R4 linear beat 1");
    step(0, 0, 0, 1, 1, 16'hFFFF, "R4 linear beat 2");
    step(0, 0, 0, 1, 1, 16'hFFFF, "R9 linear last beat");
    step(0, 0, 0, 1, 1, 16'hFFFF, "R9 linear wrap to start");
    step(0, 0, 0, 1, 1, 16'hFFFF, "R6 upper bits fixed");

    // processor strobe with enable, interleaved burst with gaps
    step(1, 1, 0, 0, 0, 16'h4562, "R3 enabled cpu load");
    step(0, 0, 0, 1, 0, 16'h0000, "R5 interleave beat 1");
    step(0, 0, 0, 0, 0, 16'h0000, "R7 hold mid burst");
    step(0, 0, 0, 1, 0, 16'h0000, "R5 interleave beat 2");
    step(0, 0, 0, 1, 0, 16'h0000, "R5 interleave last beat");
    step(0, 0, 0, 0, 1, 16'h0000, "R7 hold keeps last flag");
    step(0, 0, 0, 1, 0, 16'h0000, "R9 interleave wrap");

    // gated processor strobe has no effect
    step(0, 1, 0, 0, 0, 16'h7777, "R3 gated cpu strobe hold");
    step(0, 1, 0, 1, 1, 16'h7777, "R3 gated cpu strobe advance");

    // load wins over advance
    step(1, 1, 0, 1, 1, 16'h89AB, "R8 load beats advance");
    step(0, 0, 1, 1, 0, 16'hCDEF, "R8 controller load with advance");
    step(0, 0, 0, 1, 0, 16'h0000, "R5 interleave from 3");

    // loads on every cycle
    for (int i = 0; i < 8; i++)
      step(i % 2, i % 2, (i + 1) % 2, 1, 1, 16'(16'h1000 + i * 16'h0111), "R10 back-to-back load");
    step(0, 0, 0, 0, 1, 16'h0000, "R7 idle after loads");

    @(negedge clk); chip_en = 0; load_cpu = 0; load_ctl = 0; step_i = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule